// File: doc/BRIEF.md
# Block-Write Configuration Register Slave

This block is a two-wire serial slave that holds a small bank of 8-bit configuration registers for a clock generator. The bus lines are sampled with the system clock. The block recognises start and stop conditions, shifts in the address byte and answers only to its own 7-bit address. A write transfer always begins with two bytes that the slave acknowledges and throws away: a command code and a byte count. Every byte after those two is stored in register 0, then register 1, and so on upward. There is no register pointer.

A read transfer returns the stored bytes starting at register 0, one per acknowledged byte, with no length byte in front. The controller may end a write with a stop after any complete byte. A power-down input silences the slave without touching the stored values. The register bank leaves the block as one flat vector, and the data line is driven only through an open-drain enable.

Top module: `cfgslv_top`

## Requirements
- R1: The slave acknowledges address byte 0xD2 (write) and 0xD3 (read): 7-bit address 0x69, with bit 0 = 1 meaning read. Any other address byte is not acknowledged, and the slave ignores the bus until the next start.
- R2: In a write, the first two bytes after the address are acknowledged and change no register.
- R3: The write bytes after the two discarded ones land in registers 0, 1, 2, … in strictly ascending order. Register i appears at cfg_regs[8*i+7:8*i].
- R4: A stop after any complete byte ends the write. Registers already written keep their new values, and the others are unchanged. Registers change only as a result of a stored write byte.
- R5: After reset, register 0 holds 0x00, registers 1 to 6 hold 0xFF, and sda_oe is 0.
- R6: A read returns register 0 first and then the following registers in order, MSB first. Bytes requested beyond the last register read as 0xFF. A not-acknowledge from the controller ends the read.
- R7: While pwr_dn is 1, sda_oe stays 0, bus traffic neither acknowledges nor writes, and all register contents are retained.
- R8: Write bytes beyond register 6 are acknowledged and discarded.
- R9: sda_oe changes only while SCL is low.
- R10: For every byte the slave receives and accepts, it pulls SDA low for the whole high phase of the ninth clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_dn | input | 1 | Power-down: bus ignored, registers held |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| cfg_regs | output | 56 | Register bank, register i at bits 8*i+7:8*i |

## Verification
The hardest case to reach is a write that runs past the end of the bank. The byte counter must saturate while acknowledges continue, and no register may be hit twice. The stimulus reaches it with one long block write of nine data bytes after the two discarded bytes, then checks that the extra bytes were acknowledged and that register 6 holds the seventh byte, not the ninth. A read that requests one byte more than the bank holds covers the matching read-side boundary. A transfer sent entirely while power-down is high shows that the slave stays silent and the bank keeps its contents.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } link_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/cfgslv_sync.sv
module cfgslv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], line_i};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.chain <= '1;
            s_q.prev  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign level_o = s_q.chain[STAGES-1];
    assign rise_o  = s_q.chain[STAGES-1] & ~s_q.prev;
    assign fall_o  = ~s_q.chain[STAGES-1] & s_q.prev;

endmodule

// File: rtl/cfgslv_link.sv
module cfgslv_link
    import cfgslv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_REGS = 7,
    parameter int         IW       = $clog2(NUM_REGS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_dn,
    input  logic          scl_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_lvl,
    input  logic          sda_rise,
    input  logic          sda_fall,
    input  logic [7:0]    rd_data,
    output logic [IW-1:0] rd_idx,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [7:0]    wr_data,
    output logic          sda_oe
);

    localparam int            CW       = $clog2(NUM_REGS + 3);
    localparam logic [CW-1:0] SKIP     = CW'(2);
    localparam logic [CW-1:0] WCNT_TOP = CW'(NUM_REGS + 2);
    localparam logic [IW-1:0] RIDX_TOP = IW'(NUM_REGS);

    typedef struct packed {
        link_state_e   state;
        logic [3:0]    bcnt;
        logic [7:0]    shreg;
        logic          rw;
        logic [CW-1:0] wcnt;
        logic [IW-1:0] ridx;
        logic          mack;
        logic          wr_en;
        logic [IW-1:0] wr_idx;
        logic [7:0]    wr_data;
        logic          oe;
    } link_t;

    link_t l_d, l_q;
    logic  bus_start, bus_stop;

    assign bus_start = scl_lvl & sda_fall;
    assign bus_stop  = scl_lvl & sda_rise;

    always_comb begin
        l_d       = l_q;
        l_d.wr_en = 1'b0;

        if (pwr_dn) begin
            l_d.state = ST_IDLE;
            l_d.bcnt  = '0;
        end else if (bus_start) begin
            l_d.state = ST_ADDR;
            l_d.bcnt  = '0;
            l_d.ridx  = '0;
        end else if (bus_stop) begin
            l_d.state = ST_IDLE;
        end else begin
            unique case (l_q.state)
                ST_ADDR, ST_RX: begin
                    if (scl_rise && l_q.bcnt < 4'd8) begin
                        l_d.shreg = {l_q.shreg[6:0], sda_lvl};
                        l_d.bcnt  = l_q.bcnt + 4'd1;
                    end else if (scl_fall && l_q.bcnt == 4'd8) begin
                        if (l_q.state == ST_ADDR) begin
                            if (l_q.shreg[7:1] == DEV_ADDR) begin
                                l_d.state = ST_ADDR_ACK;
                                l_d.rw    = l_q.shreg[0];
                            end else begin
                                l_d.state = ST_IDLE;
                            end
                        end else begin
                            l_d.state = ST_RX_ACK;
                            if (l_q.wcnt >= SKIP && l_q.wcnt < WCNT_TOP) begin
                                l_d.wr_en   = 1'b1;
                                l_d.wr_idx  = IW'(l_q.wcnt - SKIP);
                                l_d.wr_data = l_q.shreg;
                            end
                            if (l_q.wcnt != WCNT_TOP) begin
                                l_d.wcnt = l_q.wcnt + CW'(1);
                            end
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        l_d.bcnt = '0;
                        l_d.wcnt = '0;
                        if (l_q.rw) begin
                            l_d.state = ST_TX;
                            l_d.shreg = rd_data;
                            if (l_q.ridx != RIDX_TOP) begin
                                l_d.ridx = l_q.ridx + IW'(1);
                            end
                        end else begin
                            l_d.state = ST_RX;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        l_d.state = ST_RX;
                        l_d.bcnt  = '0;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (l_q.bcnt == 4'd7) begin
                            l_d.state = ST_TX_ACK;
                        end else begin
                            l_d.shreg = {l_q.shreg[6:0], 1'b1};
                            l_d.bcnt  = l_q.bcnt + 4'd1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        l_d.mack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (l_q.mack) begin
                            l_d.state = ST_TX;
                            l_d.bcnt  = '0;
                            l_d.shreg = rd_data;
                            if (l_q.ridx != RIDX_TOP) begin
                                l_d.ridx = l_q.ridx + IW'(1);
                            end
                        end else begin
                            l_d.state = ST_IDLE;
                        end
                    end
                end
                default: begin
                    l_d.state = ST_IDLE;
                end
            endcase
        end

        l_d.oe = (l_d.state == ST_ADDR_ACK) || (l_d.state == ST_RX_ACK) ||
                 ((l_d.state == ST_TX) && !l_d.shreg[7]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q.state   <= ST_IDLE;
            l_q.bcnt    <= '0;
            l_q.shreg   <= '0;
            l_q.rw      <= 1'b0;
            l_q.wcnt    <= '0;
            l_q.ridx    <= '0;
            l_q.mack    <= 1'b0;
            l_q.wr_en   <= 1'b0;
            l_q.wr_idx  <= '0;
            l_q.wr_data <= '0;
            l_q.oe      <= 1'b0;
        end else begin
            l_q <= l_d;
        end
    end

    assign rd_idx  = l_q.ridx;
    assign wr_en   = l_q.wr_en;
    assign wr_idx  = l_q.wr_idx;
    assign wr_data = l_q.wr_data;
    assign sda_oe  = l_q.oe;

endmodule

// File: rtl/cfgslv_regbank.sv
module cfgslv_regbank #(
    parameter int         NUM_REGS  = 7,
    parameter int         IW        = $clog2(NUM_REGS + 1),
    parameter logic [7:0] REG0_RST  = 8'h00,
    parameter logic [7:0] OTHER_RST = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IW-1:0]         rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    typedef logic [NUM_REGS-1:0][7:0] bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en && wr_idx < IW'(NUM_REGS)) begin
            bank_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                bank_q[i] <= (i == 0) ? REG0_RST : OTHER_RST;
            end
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_data   = (rd_idx < IW'(NUM_REGS)) ? bank_q[rd_idx] : 8'hFF;
    assign regs_flat = bank_q;

endmodule

// File: rtl/cfgslv_top.sv
module cfgslv_top #(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_REGS    = 7,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_dn,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_regs
);

    localparam int IW    = $clog2(NUM_REGS + 1);
    localparam int LINES = 2;

    logic [LINES-1:0] line_raw, line_lvl, line_rise, line_fall;
    logic [7:0]       rd_data;
    logic [IW-1:0]    rd_idx;
    logic             wr_en;
    logic [IW-1:0]    wr_idx;
    logic [7:0]       wr_data;

    assign line_raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        cfgslv_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (line_raw[g]),
            .level_o (line_lvl[g]),
            .rise_o  (line_rise[g]),
            .fall_o  (line_fall[g])
        );
    end

    cfgslv_link #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS),
        .IW       (IW)
    ) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_dn   (pwr_dn),
        .scl_lvl  (line_lvl[0]),
        .scl_rise (line_rise[0]),
        .scl_fall (line_fall[0]),
        .sda_lvl  (line_lvl[1]),
        .sda_rise (line_rise[1]),
        .sda_fall (line_fall[1]),
        .rd_data  (rd_data),
        .rd_idx   (rd_idx),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .sda_oe   (sda_oe)
    );

    cfgslv_regbank #(
        .NUM_REGS (NUM_REGS),
        .IW       (IW)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .regs_flat (cfg_regs)
    );

endmodule

// File: rtl/cfgslv_chk.sv
module cfgslv_chk #(
    parameter int NUM_REGS = 7,
    parameter int IW       = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pwr_dn,
    input logic                  scl_i,
    input logic                  sda_oe,
    input logic                  wr_en,
    input logic [IW-1:0]         wr_idx,
    input logic [NUM_REGS*8-1:0] cfg_regs
);

    // R7
    pwr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn && $past(pwr_dn) |-> !sda_oe);

    // R7
    pwr_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn && $past(pwr_dn) |-> !wr_en);

    // R9
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R8
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IW'(NUM_REGS)));

    // R4
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_regs));

endmodule

bind cfgslv_top cfgslv_chk #(
    .NUM_REGS (NUM_REGS),
    .IW       (IW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_dn   (pwr_dn),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .cfg_regs (cfg_regs)
);

// File: tb/cfgslv_top_tb.sv
module cfgslv_top_tb;

    localparam int NR = 7;
    localparam int Q  = 16;
    localparam int NV = 6;

    // vector: [75:68] address byte, [67:64] byte count, [63:0] bytes, first byte in [63:56]
    localparam logic [75:0] VEC [NV] = '{
        {8'hD2, 4'd5, 64'h1122A55AC3000000},
        {8'hD2, 4'd2, 64'hAABB000000000000},
        {8'hD2, 4'd8, 64'h0007010203040506},
        {8'hD4, 4'd4, 64'h0000EEEE00000000},
        {8'hD2, 4'd3, 64'hFFFF9C0000000000},
        {8'hD2, 4'd8, 64'h0101102030405060}
    };

    logic clk = 1'b0, rst_n = 1'b0, pwr_dn = 1'b0, scl = 1'b1, sda_m = 1'b1;
    logic sda_oe;
    logic [NR*8-1:0] regs;
    wire  sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    cfgslv_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_dn   (pwr_dn),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .cfg_regs (regs)
    );

    int total = 0, bad = 0, pd_drive = 0, oe_hi_change = 0;
    bit done = 1'b0;
    logic oe_prev = 1'b0;
    logic [7:0] model [NR];

    always @(negedge clk) begin
        if (pwr_dn && sda_oe) pd_drive++;
        if (sda_oe !== oe_prev && scl) oe_hi_change++;
        oe_prev = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic dly(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; dly(Q); scl = 1'b1; dly(Q); sda_m = 1'b0; dly(Q); scl = 1'b0; dly(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; dly(Q); scl = 1'b1; dly(Q); sda_m = 1'b1; dly(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; dly(Q); scl = 1'b1; dly(2*Q); scl = 1'b0; dly(Q);
        end
        sda_m = 1'b1; dly(Q); scl = 1'b1; dly(Q);
        ack = (sda_line == 1'b0);
        dly(Q); scl = 1'b0; dly(Q);
    endtask

    task automatic recv_byte(input bit last, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            dly(Q); scl = 1'b1; dly(Q); b = {b[6:0], sda_line}; dly(Q); scl = 1'b0; dly(Q);
        end
        sda_m = last; dly(Q); scl = 1'b1; dly(2*Q); scl = 1'b0; dly(Q); sda_m = 1'b1;
    endtask

    function automatic logic [NR*8-1:0] model_flat();
        logic [NR*8-1:0] f;
        for (int i = 0; i < NR; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    initial begin
        bit ack, all_ack;
        logic [7:0] a, b;
        int n;

        for (int i = 0; i < NR; i++) model[i] = (i == 0) ? 8'h00 : 8'hFF;
        dly(5);
        rst_n = 1'b1;
        dly(5);

        // R5 reset state
        chk(regs == model_flat(), "R5 reset values", 64'(regs), 64'(model_flat()));
        chk(sda_oe == 1'b0, "R5 sda_oe idle", 64'(sda_oe), 64'd0);

        // vector table: R1 R2 R3 R4 R10
        for (int v = 0; v < NV; v++) begin
            a = VEC[v][75:68];
            n = int'(VEC[v][67:64]);
            bus_start();
            send_byte(a, ack);
            chk(ack == (a == 8'hD2), "R1 address ack", 64'(ack), 64'(a == 8'hD2));
            if (ack) begin
                all_ack = 1'b1;
                for (int k = 0; k < n; k++) begin
                    b = VEC[v][63-8*k -: 8];
                    send_byte(b, ack);
                    all_ack &= ack;
                    if (k >= 2 && k - 2 < NR) model[k-2] = b;
                end
                chk(all_ack, "R10 ninth-clock ack on data bytes", 64'(all_ack), 64'd1);
            end
            bus_stop();
            dly(4);
            chk(regs == model_flat(), "R2 R3 R4 registers after transfer", 64'(regs), 64'(model_flat()));
        end

        // R8 write past the last register
        bus_start();
        send_byte(8'hD2, ack);
        all_ack = ack;
        for (int k = 0; k < 11; k++) begin
            b = 8'h0E + 8'(k);
            send_byte(b, ack);
            all_ack &= ack;
            if (k >= 2 && k - 2 < NR) model[k-2] = b;
        end
        bus_stop();
        dly(4);
        chk(all_ack, "R8 extra bytes acknowledged", 64'(all_ack), 64'd1);
        chk(regs == model_flat(), "R8 extra bytes discarded", 64'(regs), 64'(model_flat()));

        // R6 read back, one byte beyond the bank
        bus_start();
        send_byte(8'hD3, ack);
        chk(ack, "R1 read address ack", 64'(ack), 64'd1);
        for (int k = 0; k <= NR; k++) begin
            recv_byte(k == NR, b);
            chk(b == ((k < NR) ? model[k] : 8'hFF), "R6 read byte", 64'(b),
                64'((k < NR) ? model[k] : 8'hFF));
        end
        bus_stop();
        dly(4);
        chk(regs == model_flat(), "R6 read leaves registers", 64'(regs), 64'(model_flat()));

        // R7 power-down
        pwr_dn = 1'b1;
        dly(4);
        bus_start();
        send_byte(8'hD2, ack);
        chk(!ack, "R7 no ack in power-down", 64'(ack), 64'd0);
        send_byte(8'h00, ack);
        send_byte(8'h00, ack);
        send_byte(8'h77, ack);
        bus_stop();
        dly(4);
        chk(regs == model_flat(), "R7 registers retained", 64'(regs), 64'(model_flat()));
        chk(pd_drive == 0, "R7 sda never driven", 64'(pd_drive), 64'd0);
        pwr_dn = 1'b0;
        dly(4);
        bus_start();
        send_byte(8'hD2, ack);
        send_byte(8'h00, ack);
        send_byte(8'h00, ack);
        send_byte(8'h5E, ack);
        bus_stop();
        dly(4);
        model[0] = 8'h5E;
        chk(regs == model_flat(), "R7 R4 write after power-down", 64'(regs), 64'(model_flat()));

        // R9 sda_oe never moved while SCL high
        chk(oe_hi_change == 0, "R9 sda_oe change with SCL high", 64'(oe_hi_change), 64'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all requirements actual=timeout expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule